// File: doc/BRIEF.md
# Iterative Integer Divider with Dividend Width Detection

This block divides a 32-bit dividend by a 32-bit divisor, signed or unsigned, and resolves one quotient bit per clock with a restoring shift-and-subtract loop. When the operation ends, the quotient is written to the low result register and the remainder to the high result register. A one-cycle completion strobe marks that moment.

Before iterating, the block checks how far the dividend's upper bits merely repeat its sign (signed mode) or are zero (unsigned mode). A narrow dividend is pre-aligned so that the loop runs only over its significant bits. Short operands therefore finish much sooner than full-width ones.

A request is taken only while the unit is idle. A request that arrives while a division is in flight is dropped, and the busy output stays high until the running division retires. The surrounding pipeline must hold its request until busy falls.

Top module: `iter_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0) with a nonzero divisor, `lo_o` equals the quotient and `hi_o` equals the remainder of the unsigned division.
- R2: In signed mode (`signed_i`=1) with a nonzero divisor, the quotient in `lo_o` is rounded toward zero, and the remainder in `hi_o` is zero or carries the sign of the dividend.
- R3: A request is taken on a clock edge where `start_i`=1 and `busy_o`=0. `busy_o` is then high for exactly N+1 cycles. `done_o` is high for one cycle, in the cycle after busy falls. Here N is the iteration count from R4.
- R4: N is 9 when the dividend fits in 8 bits, 17 when it fits in 16 bits, 25 when it fits in 24 bits, and 32 otherwise. "Fits in k bits" means that bits [31:k-1] are all equal in signed mode, or that bits [31:k] are all zero in unsigned mode. The narrowest class that applies wins.
- R5: `start_i` asserted while `busy_o`=1 is ignored. The running division keeps its timing and results, and no further completion follows.
- R6: A zero divisor completes in the same number of cycles as a nonzero one of the same dividend class. Its results are unspecified.
- R7: After reset, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero.
- R8: `hi_o` and `lo_o` change only in a cycle where `done_o` is high, and they hold their values between operations.
- R9: A signed division of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Division request |
| signed_i | input | 1 | 1 = two's-complement operands |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion strobe |
| hi_o | output | 32 | Remainder |
| lo_o | output | 32 | Quotient |

## Verification
Several properties are checked on every cycle:
- the strobe is a single-cycle pulse that closes a busy interval;
- busy can only end through that strobe, so a mid-run request cannot restart it;
- the result registers are frozen outside the strobe;
- a busy interval never exceeds the full-width length;
- an unsigned remainder stays below the divisor, and a signed remainder follows the dividend's sign.

Only the bench scenarios can show that the quotient and remainder values are exactly right. They also show that each dividend width class, at its boundary values, gets exactly its own iteration count, and that the most-negative by minus-one case wraps as specified.

// File: rtl/divx_pkg.sv
package divx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/divx_early_in.sv
// Classifies the dividend width and returns the number of iterations needed.
module divx_early_in #(
  parameter int W       = 32,
  parameter int CLASSES = 4,
  parameter int CNT_W   = $clog2(W + 1)
) (
  input  logic [W-1:0]     val,
  input  logic             sgn,
  output logic [CNT_W-1:0] iters
);
  logic [CLASSES-1:1] narrow;

  for (genvar c = 1; c < CLASSES; c++) begin : g_cls
    localparam int K = c * W / CLASSES;
    // signed: upper bits only replicate the sign; unsigned: upper bits are zero
    assign narrow[c] = sgn ? ((&val[W-1:K-1]) | ~(|val[W-1:K-1]))
                           : ~(|val[W-1:K]);
  end

  always_comb begin
    iters = CNT_W'(W);
    for (int c = CLASSES - 1; c >= 1; c--) begin
      if (narrow[c]) iters = CNT_W'(c * W / CLASSES + 1);
    end
  end
endmodule

// File: rtl/divx_magnitude.sv
// Absolute value of an operand in signed mode, pass-through otherwise.
module divx_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] v,
  input  logic         sgn,
  output logic [W-1:0] mag,
  output logic         neg
);
  assign neg = sgn & v[W-1];
  assign mag = neg ? (~v + W'(1)) : v;
endmodule

// File: rtl/divx_datapath.sv
// Restoring shift-subtract registers: one quotient bit per step.
module divx_datapath #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [W-1:0]     dvd_mag,
  input  logic [W-1:0]     dvs_mag,
  input  logic [CNT_W-1:0] shamt,
  output logic [W-1:0]     quo,
  output logic [W-1:0]     rem
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   shifted, diff;
  logic         ge;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign ge      = ~diff[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_mag << shamt;
      dvs_q <= dvs_mag;
    end else if (step) begin
      rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], ge};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W       = 32,
  parameter int CLASSES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import divx_pkg::*;
  localparam int CNT_W = $clog2(W + 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, iters, shamt;
  logic [W-1:0]     dvd_mag, dvs_mag, quo, rem, lo_q, hi_q;
  logic             dvd_neg, dvs_neg, qneg_q, rneg_q, busy_q, done_q;
  logic             accept, step;

  assign accept = start_i & (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign shamt  = CNT_W'(W) - iters;

  divx_magnitude #(.W(W)) u_mag_a (
    .v(dividend_i), .sgn(signed_i), .mag(dvd_mag), .neg(dvd_neg));
  divx_magnitude #(.W(W)) u_mag_b (
    .v(divisor_i), .sgn(signed_i), .mag(dvs_mag), .neg(dvs_neg));

  divx_early_in #(.W(W), .CLASSES(CLASSES), .CNT_W(CNT_W)) u_early (
    .val(dividend_i), .sgn(signed_i), .iters(iters));

  divx_datapath #(.W(W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .shamt(shamt),
    .quo(quo), .rem(rem));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          cnt_q   <= iters;
          qneg_q  <= dvd_neg ^ dvs_neg;
          rneg_q  <= dvd_neg;
          busy_q  <= 1'b1;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          lo_q    <= qneg_q ? (~quo + W'(1)) : quo;
          hi_q    <= rneg_q ? (~rem + W'(1)) : rem;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  logic [W-1:0] dvd_l, dvs_l;
  logic         sgn_l;
  int unsigned  run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_l   <= '0;
      dvs_l   <= '0;
      sgn_l   <= 1'b0;
      run_len <= 0;
    end else begin
      if (start_i && !busy_o && !done_o) begin
        dvd_l <= dividend_i;
        dvs_l <= divisor_i;
        sgn_l <= signed_i;
      end
      run_len <= busy_o ? run_len + 1 : 0;
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R3
  strobe_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));
  // R5
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));
  // R6
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= W + 1);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(lo_o) && $stable(hi_o)));
  // R1
  urem_below_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !sgn_l && dvs_l != '0) |-> (hi_o < dvs_l));
  // R2
  srem_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && sgn_l && dvs_l != '0 && hi_o != '0) |-> (hi_o[W-1] == dvd_l[W-1]));
endmodule

bind iter_divider iter_divider_chk #(.W(W)) u_chk (.*);

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          signed_i = 1'b0;
  logic [DW-1:0] dividend_i = '0;
  logic [DW-1:0] divisor_i = '0;
  logic          busy_o, done_o;
  logic [DW-1:0] hi_o, lo_o;

  int total = 0;
  int fails = 0;

  iter_divider #(.W(DW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // busy-cycle count expected from the width class (N+1)
  function automatic int exp_lat(input logic [DW-1:0] a, input logic s);
    longint sa;
    sa = $signed(a);
    if (s) begin
      if (sa >= -128 && sa <= 127) return 10;
      if (sa >= -32768 && sa <= 32767) return 18;
      if (sa >= -(64'sd1 <<< 23) && sa < (64'sd1 <<< 23)) return 26;
      return 33;
    end
    if (a < 32'd256) return 10;
    if (a < 32'd65536) return 18;
    if (a < 32'h0100_0000) return 26;
    return 33;
  endfunction

  // intr_at > 0: drive a second request at that busy cycle
  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic s,
                        input int intr_at,
                        output logic [DW-1:0] q, output logic [DW-1:0] r, output int lat);
    @(negedge clk);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      if (busy_o) lat++;
      if (intr_at > 0 && lat == intr_at) begin
        start_i = 1'b1; signed_i = ~s; dividend_i = ~a; divisor_i = 32'd3;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    q = lo_o;
    r = hi_o;
    @(negedge clk);
    check("R3 strobe single", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    logic [DW-1:0] dvds [22];
    logic [DW-1:0] dvss [10];
    logic [DW-1:0] q, r, eq, er;
    int lat;

    dvds = '{32'd0, 32'd1, 32'd127, 32'd128, 32'hFFFF_FF80, 32'hFFFF_FF7F, 32'd255,
             32'd256, 32'd32767, 32'd32768, 32'hFFFF_8000, 32'hFFFF_7FFF, 32'd65535,
             32'd65536, 32'h007F_FFFF, 32'h0080_0000, 32'h00FF_FFFF, 32'h0100_0000,
             32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    dvss = '{32'd1, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFF9, 32'd255, 32'h0001_0000,
             32'h7FFF_FFFF, 32'h8000_0000, 32'd2, 32'd13};

    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 busy", {31'd0, busy_o}, 32'd0);
    check("R7 done", {31'd0, done_o}, 32'd0);
    check("R7 hi", hi_o, 32'd0);
    check("R7 lo", lo_o, 32'd0);
    rst = 1'b0;

    for (int sm = 0; sm < 2; sm++) begin
      for (int i = 0; i < 22; i++) begin
        for (int j = 0; j < 10; j++) begin
          run_op(dvds[i], dvss[j], sm[0], 0, q, r, lat);
          check("R4 latency", lat, exp_lat(dvds[i], sm[0]));
          if (sm == 0) begin
            eq = dvds[i] / dvss[j];
            er = dvds[i] % dvss[j];
            check("R1 quotient", q, eq);
            check("R1 remainder", r, er);
          end else if (dvds[i] == 32'h8000_0000 && dvss[j] == 32'hFFFF_FFFF) begin
            check("R9 quotient", q, 32'h8000_0000);
            check("R9 remainder", r, 32'd0);
          end else begin
            eq = $signed(dvds[i]) / $signed(dvss[j]);
            er = $signed(dvds[i]) % $signed(dvss[j]);
            check("R2 quotient", q, eq);
            check("R2 remainder", r, er);
          end
        end
      end
    end

    // R6: divide by zero keeps class timing
    for (int i = 0; i < 22; i++) begin
      run_op(dvds[i], 32'd0, i[0], 0, q, r, lat);
      check("R6 zero divisor latency", lat, exp_lat(dvds[i], i[0]));
    end

    // R5: request during busy is ignored
    run_op(32'd1000000, 32'd7, 1'b0, 4, q, r, lat);
    check("R5 latency", lat, 26);
    check("R5 quotient", q, 32'd142857);
    check("R5 remainder", r, 32'd1);
    run_op(32'hFFFF_FF9C, 32'd7, 1'b1, 2, q, r, lat);
    check("R5 signed latency", lat, 10);
    check("R5 signed quotient", q, 32'hFFFF_FFF2);
    check("R5 signed remainder", r, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    check("R5 no extra busy", {31'd0, busy_o}, 32'd0);

    // R8: results hold while idle inputs wiggle
    dividend_i = 32'hDEAD_BEEF; divisor_i = 32'd5; signed_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 lo hold", lo_o, 32'hFFFF_FFF2);
    check("R8 hi hold", hi_o, 32'hFFFF_FFFE);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule